// File: doc/BRIEF.md
# Serial EEPROM Slave Controller (2 KB, I2C)

This block is the target side of a 2 KB byte-addressed serial EEPROM sitting on an I2C bus. It samples the open-drain clock and data lines into its own system clock, finds Start and Stop conditions, and decodes a select byte followed by an optional address byte. It answers by pulling the data line low, either to acknowledge or to shift out read data.

Writes are gathered into a 16-byte page latch. They reach the internal register array only when a Stop closes the transfer at the right moment. The block then stays busy, and silent on the bus, for a parameterised number of clock cycles that stands for the programming time. Reads do not depend on the write-control input. A read runs from the internal address counter, which increments after every byte and wraps across the whole array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data-line pull is released and every memory byte reads FFh.
- R2: Start is SDA falling while SCL is high, and Stop is SDA rising while SCL is high. A select byte whose bits 7:4 equal 1010 is acknowledged in the ninth clock. Any other select byte gets no acknowledge, and the block ignores the bus until the next Start.
- R3: Select bits 3:1 load address bits 10:8 and bit 0 chooses read (1) or write (0). In write mode the next byte loads address bits 7:0. The select byte, the address byte and each data byte are acknowledged, and a byte write stores its data.
- R4: In a page write, address bits 10:4 stay fixed. Bits 3:0 step after each data byte and wrap from 15 to 0 within the same page, up to 16 bytes.
- R5: Data is committed only when a Stop arrives right after a data-byte acknowledge. A Stop after the address byte, or in the middle of a data byte, writes nothing and starts no busy period.
- R6: With write-control high, the select and address bytes are still acknowledged. Every data byte gets NoAck, memory is unchanged and no busy period starts.
- R7: After a commit the block is busy for WRITE_CYCLES clock cycles. During that time it never pulls SDA, so select bytes get no acknowledge. Afterwards it responds again.
- R8: After a committed write, the address counter holds the address one past the last byte written.
- R9: A random read is a write-mode select, an address byte, a repeated Start and a read-mode select. It returns the byte at that address.
- R10: During a read the counter advances after each byte and wraps from 7FFh to 000h. A master acknowledge continues the stream with the next byte.
- R11: A master NoAck in the ninth clock of a read ends the transfer and releases SDA. Reads work whatever the write-control level.
- R12: The SDA pull changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| wc_i | input | 1 | Write control, high blocks data writes |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
The assertions assume a well-formed master. It changes SDA only while SCL is low, except to form Start and Stop. It never raises SDA against the slave's pull. It holds write-control steady for the whole of a transaction. Each SCL phase is long enough to pass the two-flop synchroniser. The bench master keeps each SCL half-period at eight system cycles and moves data two cycles after the falling edge. It forms Start and Stop only with SCL high and the slave released, and it toggles write-control only between transactions.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_ADDR, S_WDATA, S_RDATA, S_BUSY
  } st_e;
  localparam logic [3:0] DEV_ID = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_o     = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
endmodule

// File: rtl/page_buf.sv
module page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_N = 1 << PAGE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           wr_i,
  input  logic [PAGE_W-1:0]              idx_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [PAGE_N-1:0][DATA_W-1:0]  data_o,
  output logic [PAGE_N-1:0]              mask_o
);
  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g] <= '0;
        mask_o[g] <= 1'b0;
      end else if (clr_i) begin
        mask_o[g] <= 1'b0;
      end else if (wr_i && idx_i == PAGE_W'(g)) begin
        data_o[g] <= data_i;
        mask_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PAGE_N = 1 << PAGE_W,
  localparam int PG_W   = ADDR_W - PAGE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [PG_W-1:0]               page_i,
  input  logic [PAGE_N-1:0][DATA_W-1:0] wdata_i,
  input  logic [PAGE_N-1:0]             mask_i,
  input  logic [ADDR_W-1:0]             raddr_i,
  output logic [DATA_W-1:0]             rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we_i) begin
      for (int j = 0; j < PAGE_N; j++)
        if (mask_i[j]) mem[{page_i, PAGE_W'(j)}] <= wdata_i[j];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic sda_pull_o
);
  localparam int DATA_W = 8;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  st_e                state;
  logic [3:0]         bitcnt;
  logic [DATA_W-1:0]  shreg, txsh, rdata;
  logic               in_ack, acked, rd, commit_ok;
  logic [ADDR_W-1:0]  ptr, last_addr;
  logic [CNT_W-1:0]   busy_cnt;
  logic [PAGE_N-1:0][DATA_W-1:0] buf_data;
  logic [PAGE_N-1:0]  buf_mask;
  logic               buf_wr, buf_clr, mem_we, byte_done;

  i2c_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  assign byte_done = scl_fall & ~in_ack & (bitcnt == 4'd8);
  assign buf_wr    = (state == S_WDATA) & byte_done & ~wc_i;
  assign mem_we    = stop & commit_ok & (state == S_WDATA);
  assign buf_clr   = (start & (state != S_BUSY)) | mem_we;

  page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .idx_i(ptr[PAGE_W-1:0]), .data_i(shreg),
    .data_o(buf_data), .mask_o(buf_mask)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .page_i(last_addr[ADDR_W-1:PAGE_W]),
    .wdata_i(buf_data), .mask_i(buf_mask), .raddr_i(ptr), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= S_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txsh       <= '0;
      in_ack     <= 1'b0;
      acked      <= 1'b0;
      rd         <= 1'b0;
      commit_ok  <= 1'b0;
      ptr        <= '0;
      last_addr  <= '0;
      busy_cnt   <= '0;
      sda_pull_o <= 1'b0;
    end else if (state == S_BUSY) begin
      if (busy_cnt == CNT_W'(WRITE_CYCLES - 1)) begin
        busy_cnt <= '0;
        state    <= S_IDLE;
      end else begin
        busy_cnt <= busy_cnt + 1'b1;
      end
    end else if (stop) begin
      sda_pull_o <= 1'b0;
      in_ack     <= 1'b0;
      commit_ok  <= 1'b0;
      if (mem_we) begin
        state <= S_BUSY;
        ptr   <= last_addr + 1'b1;
      end else begin
        state <= S_IDLE;
      end
    end else if (start) begin
      state      <= S_SEL;
      bitcnt     <= '0;
      in_ack     <= 1'b0;
      commit_ok  <= 1'b0;
      sda_pull_o <= 1'b0;
    end else begin
      // only a Stop before the next falling SCL edge may commit
      if (scl_fall) commit_ok <= 1'b0;
      unique case (state)
        S_SEL, S_ADDR, S_WDATA: begin
          if (!in_ack) begin
            if (scl_rise) begin
              shreg  <= {shreg[DATA_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              in_ack <= 1'b1;
              acked  <= 1'b0;
              if (state == S_SEL) begin
                if (shreg[7:4] == DEV_ID) begin
                  sda_pull_o          <= 1'b1;
                  acked               <= 1'b1;
                  ptr[ADDR_W-1:DATA_W] <= shreg[HI_W:1];
                  rd                  <= shreg[0];
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_ADDR) begin
                sda_pull_o         <= 1'b1;
                acked              <= 1'b1;
                ptr[DATA_W-1:0]    <= shreg;
              end else if (!wc_i) begin
                sda_pull_o         <= 1'b1;
                acked              <= 1'b1;
                last_addr          <= ptr;
                ptr[PAGE_W-1:0]    <= ptr[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
              end
            end
          end else if (scl_fall) begin
            in_ack     <= 1'b0;
            sda_pull_o <= 1'b0;
            if (state == S_SEL) begin
              if (rd) begin
                state      <= S_RDATA;
                txsh       <= rdata;
                sda_pull_o <= ~rdata[7];
              end else begin
                state <= S_ADDR;
              end
            end else if (state == S_ADDR) begin
              state <= S_WDATA;
            end else begin
              commit_ok <= acked;
            end
          end
        end
        S_RDATA: begin
          if (!in_ack) begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                bitcnt     <= '0;
                in_ack     <= 1'b1;
                sda_pull_o <= 1'b0;
                ptr        <= ptr + 1'b1;
              end else begin
                txsh       <= {txsh[DATA_W-2:0], 1'b0};
                sda_pull_o <= ~txsh[DATA_W-2];
              end
            end
          end else if (scl_rise) begin
            acked <= ~sda_s;
          end else if (scl_fall) begin
            in_ack <= 1'b0;
            if (acked) begin
              txsh       <= rdata;
              sda_pull_o <= ~rdata[7];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
  import eeprom_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic sda_pull_i,
  input logic wc_i,
  input st_e  state_i,
  input logic in_ack_i,
  input int   wcyc_i
);
  int run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run <= 0;
    else if (state_i == S_BUSY) run <= run + 1;
    else run <= 0;
  end

  AST_BUSY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_BUSY |-> !sda_pull_i); // R7
  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run <= wcyc_i); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_IDLE |-> !sda_pull_i); // R2
  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_i) |-> !scl_s_i); // R12
  AST_WC_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_WDATA && in_ack_i && wc_i) |-> !sda_pull_i); // R6
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_i == S_BUSY) |-> $past(state_i) == S_WDATA); // R5
  AST_ACK_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_i && state_i != S_RDATA) |-> in_ack_i); // R3
endmodule

bind i2c_eeprom_slave eeprom_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_pull_i(sda_pull_o),
  .wc_i(wc_i), .state_i(state), .in_ack_i(in_ack), .wcyc_i(WRITE_CYCLES)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int WCYC = 400;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic pull, bus;
  int checks = 0, errors = 0;
  logic [7:0] mem_m [2048];
  int ptr_m = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  assign bus = sda_m & ~pull;

  i2c_eeprom_slave #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(bus),
    .wc_i(wc), .sda_pull_o(pull)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor: pull must only move while SCL is low (R12)
  logic prev_pull = 1'b0;
  int r12_viol = 0;
  always @(negedge clk) begin
    if (rst_n && pull != prev_pull && scl_m) begin
      r12_viol++;
      $display("FAIL R12 pull changed with SCL high actual=%0d expected=%0d", pull, prev_pull);
    end
    prev_pull <= pull;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_x(input logic b, output logic s);
    wt(2); sda_m = b; wt(6); scl_m = 1'b1; wt(4); s = bus; wt(4); scl_m = 1'b0;
  endtask

  task automatic start_c();
    wt(6); sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4); sda_m = 1'b0; wt(4); scl_m = 1'b0;
  endtask

  task automatic stop_c();
    wt(2); sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(4); sda_m = 1'b1; wt(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); b[i] = s; end
    bit_x(~mack, s);
  endtask

  task automatic sel(input int hi, input logic rw, input logic exp, input string req);
    logic a;
    send_byte({4'b1010, hi[2:0], rw}, a);
    chk(req, a, exp);
    if (exp) ptr_m = (hi << 8) | (ptr_m & 8'hFF);
  endtask

  task automatic rd_n(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, b);
      chk(req, b, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) & 11'h7FF;
    end
  endtask

  task automatic wr(input int addr, input logic [7:0] q[$], input string req);
    logic a;
    int ad;
    start_c();
    sel(addr >> 8, 1'b0, 1'b1, req);
    send_byte(addr[7:0], a); chk(req, a, 1);
    ptr_m = addr;
    for (int k = 0; k < q.size(); k++) begin
      send_byte(q[k], a);
      chk(req, a, !wc);
      ad = (addr & 11'h7F0) | ((addr + k) & 4'hF);
      if (!wc) begin mem_m[ad] = q[k]; ptr_m = (ad + 1) & 11'h7FF; end
    end
    stop_c();
  endtask

  task automatic rrd(input int addr, input int n, input string req);
    logic a;
    start_c();
    sel(addr >> 8, 1'b0, 1'b1, req);
    send_byte(addr[7:0], a); chk(req, a, 1);
    ptr_m = addr;
    start_c();
    sel(addr >> 8, 1'b1, 1'b1, req);
    rd_n(n, req);
    stop_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic s;
    for (int i = 0; i < 2048; i++) mem_m[i] = 8'hFF;
    wt(5); rst_n = 1'b1; wt(10);
    chk("R1 pull released after reset", pull, 0);

    // R1 current read at 000 after reset
    start_c(); sel(0, 1'b1, 1'b1, "R2 select ack"); rd_n(1, "R1 erased byte"); stop_c();

    // R3 byte write then R7 busy poll
    wr(11'h124, '{8'h33}, "R3 byte write ack");
    start_c(); sel(1, 1'b0, 1'b0, "R7 busy no ack"); stop_c();
    wt(WCYC + 50);
    start_c(); sel(1, 1'b0, 1'b1, "R7 ack after busy"); stop_c();
    wr(11'h123, '{8'h5A}, "R3 byte write ack");
    wt(WCYC + 50);
    start_c(); sel(1, 1'b1, 1'b1, "R8 select"); rd_n(1, "R8 counter past last write"); stop_c();
    rrd(11'h123, 1, "R9 random read");

    // R4 page wrap
    wr(11'h04E, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, "R4 page write ack");
    wt(WCYC + 50);
    rrd(11'h04E, 3, "R4 page tail and next page untouched");
    rrd(11'h040, 2, "R4 wrapped bytes at page start");

    // R5 stop after address and mid data byte
    start_c(); sel(0, 1'b0, 1'b1, "R5 select");
    send_byte(8'h60, a); chk("R5 addr ack", a, 1); stop_c();
    start_c(); sel(0, 1'b0, 1'b1, "R5 not busy after addr stop"); stop_c();
    start_c(); sel(0, 1'b0, 1'b1, "R5 select");
    send_byte(8'h61, a); chk("R5 addr ack", a, 1);
    for (int i = 0; i < 4; i++) bit_x(1'b0, s);
    stop_c();
    start_c(); sel(0, 1'b0, 1'b1, "R5 not busy after mid stop"); stop_c();
    rrd(11'h060, 2, "R5 nothing written");

    // R6 write control
    wc = 1'b1; wt(4);
    wr(11'h200, '{8'h11, 8'h22}, "R6 data nack under wc");
    start_c(); sel(2, 1'b0, 1'b1, "R6 no busy under wc"); stop_c();
    rrd(11'h200, 2, "R11 read with wc high, R6 unchanged");
    wc = 1'b0; wt(4);

    // R10 wrap of read counter
    wr(11'h7FF, '{8'hC3}, "R10 setup");
    wt(WCYC + 50);
    wr(11'h000, '{8'h3C}, "R10 setup");
    wt(WCYC + 50);
    rrd(11'h7FF, 2, "R10 sequential wrap");
    chk("R11 released after master nack", pull, 0);
    start_c(); sel(0, 1'b1, 1'b1, "R11 select"); rd_n(1, "R11 counter after nack end"); stop_c();

    // R2 mismatch
    start_c();
    send_byte(8'hB0, a); chk("R2 foreign select nack", a, 0);
    send_byte(8'hA0, a); chk("R2 ignored until start", a, 0);
    stop_c();

    checks++;
    if (r12_viol != 0) errors++;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule